// File: doc/BRIEF.md
# Floating-Point Control and Exception Status Register

This block is the single control/status word of a floating-point coprocessor. It holds the rounding mode that the arithmetic units read, the condition bit that compare operations leave for the branch logic, and three five-bit exception fields. The cause field describes the most recently completed operation. The sticky field gathers every cause raised since software last cleared it. The enable field selects which causes interrupt the CPU.

The arithmetic units report each completed operation with a strobe and a five-bit flag vector. The compare unit reports its outcome with its own strobe. The CPU moves the whole word in and out through one write port and a combinational read port. When an enabled cause is recorded, whether it comes from an operation or from a CPU write, the block raises a one-cycle trap request. That request appears in the same cycle that the new cause bits become visible. When overflow is recorded with its enable clear, no trap is raised and the arithmetic unit returns a signed infinity on its own.

Top module: `fpu_csr`

## Requirements
- R1: After a synchronous active-low reset, every field is zero: the read word is 0, the rounding mode is 00 (nearest-even), the condition bit is 0 and trap_req is low.
- R2: The word layout is: bits [1:0] rounding mode, [6:2] sticky, [11:7] trap enable, [16:12] cause, bit 23 condition. Inside each five-bit field, bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid. A CPU write loads every field from the write data. All other bits read as 0 whatever was written to them.
- R3: The rounding mode encodes 00 nearest-even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity. It drives the rmode output and changes only on a CPU write.
- R4: An operation strobe replaces the whole cause field with the reported flags. This clears causes that are not reported again.
- R5: An operation strobe ORs the reported flags into the sticky field. Sticky bits stay set until a CPU write clears them.
- R6: A compare strobe loads the condition bit from the compare result. Without a strobe the condition bit holds.
- R7: An operation that reports a cause whose enable is set drives trap_req high for exactly one cycle. That cycle is the same cycle in which the new cause bits first read back.
- R8: An overflow reported with its enable clear raises no trap. Overflow is still recorded in the cause and sticky fields.
- R9: A CPU write whose cause field and enable field share a set bit raises the one-cycle trap request in the next cycle. A write with no such overlap raises none.
- R10: When a CPU write coincides with an operation strobe or a compare strobe, the CPU write alone decides the new contents, and the coinciding event is discarded.
- R11: Flags presented while the operation strobe is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_done | input | 1 | Strobe: an arithmetic operation completed |
| op_flags | input | 5 | Exception flags of that operation (R2 bit order) |
| cmp_done | input | 1 | Strobe: a compare completed |
| cmp_true | input | 1 | Outcome of that compare |
| cpu_wr | input | 1 | CPU write of the whole word |
| cpu_wdata | input | 32 | Word written by the CPU |
| cpu_rdata | output | 32 | Current word, read by the CPU |
| rmode | output | 2 | Rounding mode to the arithmetic units |
| cond | output | 1 | Condition bit to the branch logic |
| trap_req | output | 1 | One-cycle trap request to the CPU |

## Verification
The bench targets four corner cases.

- An operation with no flags must wipe the previous causes while the sticky bits survive. A design that merged causes would keep stale bits, and one that rebuilt sticky from the causes would lose history.
- The trap must last one cycle even though the cause bit stays set. A design that derives trap_req from the cause and enable levels would hold it high.
- Overflow with its enable clear must be recorded without a trap. A write that sets an enabled cause must trap, while a write whose cause and enable bits do not overlap must not.
- A CPU write that lands together with an operation strobe and a compare strobe must leave exactly the written word. A design that gave priority to the event would show extra flags or a flipped condition bit.

// File: rtl/fcsr_pkg.sv
// Package: fcsr_pkg
// Shared field layout and types for the floating-point control/status word.
// Assumes a 32-bit word and five exception causes.
package fcsr_pkg;
    localparam int NCAUSE   = 5;
    localparam int CSR_W    = 32;
    localparam int RM_W     = 2;
    localparam int RM_LSB   = 0;
    localparam int STK_LSB  = RM_LSB + RM_W;
    localparam int ENA_LSB  = STK_LSB + NCAUSE;
    localparam int CAU_LSB  = ENA_LSB + NCAUSE;
    localparam int COND_BIT = 23;

    // Cause bit positions inside every five-bit field
    localparam int C_INEXACT   = 0;
    localparam int C_UNDERFLOW = 1;
    localparam int C_OVERFLOW  = 2;
    localparam int C_DIVZERO   = 3;
    localparam int C_INVALID   = 4;

    typedef logic [NCAUSE-1:0] cause_vec_t;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_PLUSINF = 2'b10,
        RM_MININF  = 2'b11
    } rmode_e;
endpackage

// File: rtl/fcsr_mode_reg.sv
// Module: fcsr_mode_reg
// Holds the rounding mode and the compare condition bit.
// Assumes that a CPU write has priority over a coinciding compare strobe.
module fcsr_mode_reg
    import fcsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  rmode_e          wr_rmode,
    input  logic            wr_cond,
    input  logic            cmp_valid,
    input  logic            cmp_result,
    output rmode_e          rmode_q,
    output logic            cond_q
);

    // Rounding mode: reset to nearest-even, loaded only by CPU writes
    always_ff @(posedge clk) begin
        if (!rst_n)     rmode_q <= RM_NEAREST;
        else if (wr_en) rmode_q <= wr_rmode;
    end

    // Condition bit: CPU write first, then compare outcome
    always_ff @(posedge clk) begin
        if (!rst_n)         cond_q <= 1'b0;
        else if (wr_en)     cond_q <= wr_cond;
        else if (cmp_valid) cond_q <= cmp_result;
    end

    assert_rmode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rmode_q));
    assert_cond_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !wr_en) |=> (cond_q == $past(cmp_result)));
    assert_cond_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !wr_en) |=> $stable(cond_q));
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rmode_q == $past(wr_rmode)) && (cond_q == $past(wr_cond)));

endmodule

// File: rtl/fcsr_flag_bank.sv
// Module: fcsr_flag_bank
// Per-cause cause, sticky and enable bits, one generated cell per cause.
// Assumes that a CPU write overrides a coinciding operation strobe.
module fcsr_flag_bank
    import fcsr_pkg::*;
#(
    parameter int N = NCAUSE
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_cause,
    input  logic [N-1:0] wr_sticky,
    input  logic [N-1:0] wr_enable,
    input  logic         exc_valid,
    input  logic [N-1:0] exc_flags,
    output logic [N-1:0] cause_q,
    output logic [N-1:0] sticky_q,
    output logic [N-1:0] enable_q
);

    for (genvar gi = 0; gi < N; gi++) begin : g_cell
        // Cause bit: overwritten by every completed operation
        always_ff @(posedge clk) begin
            if (!rst_n)         cause_q[gi] <= 1'b0;
            else if (wr_en)     cause_q[gi] <= wr_cause[gi];
            else if (exc_valid) cause_q[gi] <= exc_flags[gi];
        end

        // Sticky bit: accumulates until software rewrites it
        always_ff @(posedge clk) begin
            if (!rst_n)                         sticky_q[gi] <= 1'b0;
            else if (wr_en)                     sticky_q[gi] <= wr_sticky[gi];
            else if (exc_valid && exc_flags[gi]) sticky_q[gi] <= 1'b1;
        end

        // Enable bit: software-owned
        always_ff @(posedge clk) begin
            if (!rst_n)     enable_q[gi] <= 1'b0;
            else if (wr_en) enable_q[gi] <= wr_enable[gi];
        end
    end

    assert_cause_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !wr_en) |=> (cause_q == $past(exc_flags)));
    assert_sticky_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
    assert_sticky_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !wr_en) |=> ((sticky_q & $past(exc_flags)) == $past(exc_flags)));
    assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && !wr_en) |=> ($stable(cause_q) && $stable(sticky_q) && $stable(enable_q)));

endmodule

// File: rtl/fcsr_trap_gen.sv
// Module: fcsr_trap_gen
// Registered one-cycle trap request, aligned with the cause update.
// Assumes that operation causes are gated by the enables already held.
module fcsr_trap_gen
    import fcsr_pkg::*;
#(
    parameter int N = NCAUSE
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_cause,
    input  logic [N-1:0] wr_enable,
    input  logic         exc_valid,
    input  logic [N-1:0] exc_flags,
    input  logic [N-1:0] enable_q,
    output logic         trap_q
);

    logic hit_wr;
    logic hit_exc;

    // Detect an enabled cause in the incoming event
    always_comb begin
        hit_wr  = |(wr_cause & wr_enable);
        hit_exc = |(exc_flags & enable_q);
    end

    // Trap pulse: one cycle per triggering event
    always_ff @(posedge clk) begin
        if (!rst_n)         trap_q <= 1'b0;
        else if (wr_en)     trap_q <= hit_wr;
        else if (exc_valid) trap_q <= hit_exc;
        else                trap_q <= 1'b0;
    end

    assert_trap_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $past(wr_en || exc_valid));
    assert_trap_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !wr_en && ((exc_flags & enable_q) == '0)) |=> !trap_q);
    assert_trap_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_cause & wr_enable) != '0)) |=> trap_q);

endmodule

// File: rtl/fpu_csr.sv
// Module: fpu_csr
// Floating-point control/status word: rounding mode, condition bit,
// cause/sticky/enable exception fields and trap request.
// Assumes single-cycle strobes from the arithmetic and compare units.
module fpu_csr
    import fcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_done,
    input  logic [NCAUSE-1:0]   op_flags,
    input  logic                cmp_done,
    input  logic                cmp_true,
    input  logic                cpu_wr,
    input  logic [CSR_W-1:0]    cpu_wdata,
    output logic [CSR_W-1:0]    cpu_rdata,
    output logic [RM_W-1:0]     rmode,
    output logic                cond,
    output logic                trap_req
);

    cause_vec_t w_cause, w_sticky, w_enable;
    rmode_e     w_rmode;
    cause_vec_t cause_q, sticky_q, enable_q;
    rmode_e     rmode_q;
    logic       cond_q;

    // Unpack the CPU write word into fields
    always_comb begin
        w_rmode  = rmode_e'(cpu_wdata[RM_LSB +: RM_W]);
        w_sticky = cpu_wdata[STK_LSB +: NCAUSE];
        w_enable = cpu_wdata[ENA_LSB +: NCAUSE];
        w_cause  = cpu_wdata[CAU_LSB +: NCAUSE];
    end

    fcsr_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_wr),
        .wr_rmode   (w_rmode),
        .wr_cond    (cpu_wdata[COND_BIT]),
        .cmp_valid  (cmp_done),
        .cmp_result (cmp_true),
        .rmode_q    (rmode_q),
        .cond_q     (cond_q)
    );

    fcsr_flag_bank #(.N(NCAUSE)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr),
        .wr_cause  (w_cause),
        .wr_sticky (w_sticky),
        .wr_enable (w_enable),
        .exc_valid (op_done),
        .exc_flags (op_flags),
        .cause_q   (cause_q),
        .sticky_q  (sticky_q),
        .enable_q  (enable_q)
    );

    fcsr_trap_gen #(.N(NCAUSE)) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr),
        .wr_cause  (w_cause),
        .wr_enable (w_enable),
        .exc_valid (op_done),
        .exc_flags (op_flags),
        .enable_q  (enable_q),
        .trap_q    (trap_req)
    );

    // Pack the fields into the read word; unused bits read zero
    always_comb begin
        cpu_rdata                       = '0;
        cpu_rdata[RM_LSB +: RM_W]       = rmode_q;
        cpu_rdata[STK_LSB +: NCAUSE]    = sticky_q;
        cpu_rdata[ENA_LSB +: NCAUSE]    = enable_q;
        cpu_rdata[CAU_LSB +: NCAUSE]    = cause_q;
        cpu_rdata[COND_BIT]             = cond_q;
    end

    // Drive the side outputs
    always_comb begin
        rmode = rmode_q;
        cond  = cond_q;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_rdata == '0) && !trap_req);
    assert_ovf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !cpu_wr && op_flags[C_OVERFLOW] && !enable_q[C_OVERFLOW]
         && ((op_flags & enable_q) == '0))
        |=> !trap_req && cause_q[C_OVERFLOW] && sticky_q[C_OVERFLOW]);

endmodule

// File: tb/fpu_csr_tb.sv
module fpu_csr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        cmp_done = 1'b0;
    logic        cmp_true = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [1:0]  rmode;
    logic        cond;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpu_csr u_dut (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
        .cmp_done(cmp_done), .cmp_true(cmp_true), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rmode(rmode),
        .cond(cond), .trap_req(trap_req)
    );

    function automatic logic [31:0] word(input logic [1:0] rm, input logic [4:0] stk,
                                         input logic [4:0] ena, input logic [4:0] cau,
                                         input logic cb);
        word = {8'd0, cb, 6'd0, cau, ena, stk, rm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One CPU write, returns at the negedge after the update edge
    task automatic cpu_write(input logic [31:0] d);
        cpu_wr = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = '0;
    endtask

    task automatic op(input logic [4:0] f);
        op_done = 1'b1; op_flags = f;
        @(negedge clk);
        op_done = 1'b0; op_flags = '0;
    endtask

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 32'h0);
        check("R1 rmode", {30'd0, rmode}, 32'h0);
        check("R1 trap", {31'd0, trap_req}, 32'h0);
    endtask

    task automatic t_layout();
        cpu_write(32'hFF7E_0000 | word(2'b10, 5'h15, 5'h0A, 5'h00, 1'b1));
        check("R2 readback", cpu_rdata, word(2'b10, 5'h15, 5'h0A, 5'h00, 1'b1));
        check("R2 cond", {31'd0, cond}, 32'd1);
        check("R2 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_rmode();
        for (int m = 0; m < 4; m++) begin
            cpu_write(word(2'(m), 5'h0, 5'h0, 5'h0, 1'b0));
            check("R3 mode", {30'd0, rmode}, 32'(m));
        end
        op(5'h1F);
        cmp_done = 1'b1; cmp_true = 1'b1;
        @(negedge clk);
        cmp_done = 1'b0; cmp_true = 1'b0;
        check("R3 held", {30'd0, rmode}, 32'd3);
    endtask

    task automatic t_cause_sticky();
        cpu_write(32'h0);
        op(5'b00001);
        check("R4 cause1", cpu_rdata, word(2'b00, 5'b00001, 5'h0, 5'b00001, 1'b0));
        op(5'b00100);
        check("R4 R5 cause2", cpu_rdata, word(2'b00, 5'b00101, 5'h0, 5'b00100, 1'b0));
        op(5'b00000);
        check("R4 cleared R5 kept", cpu_rdata, word(2'b00, 5'b00101, 5'h0, 5'h0, 1'b0));
        cpu_write(32'h0);
        check("R5 sw clear", cpu_rdata, 32'h0);
    endtask

    task automatic t_idle();
        cpu_write(word(2'b01, 5'h02, 5'h1F, 5'h02, 1'b0));
        @(negedge clk);
        op_done = 1'b0; op_flags = 5'h1F;
        @(negedge clk);
        op_flags = '0;
        check("R11 unchanged", cpu_rdata, word(2'b01, 5'h02, 5'h1F, 5'h02, 1'b0));
        check("R11 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_cmp();
        cpu_write(32'h0);
        cmp_done = 1'b1; cmp_true = 1'b1;
        @(negedge clk);
        cmp_done = 1'b0;
        check("R6 set", {31'd0, cond}, 32'd1);
        @(negedge clk);
        check("R6 hold", {31'd0, cond}, 32'd1);
        cmp_done = 1'b1; cmp_true = 1'b0;
        @(negedge clk);
        cmp_done = 1'b0;
        check("R6 clear", {31'd0, cond}, 32'd0);
    endtask

    task automatic t_trap();
        cpu_write(word(2'b00, 5'h0, 5'b00100, 5'h0, 1'b0));
        op(5'b00100);
        check("R7 pulse", {31'd0, trap_req}, 32'd1);
        check("R7 cause aligned", cpu_rdata, word(2'b00, 5'b00100, 5'b00100, 5'b00100, 1'b0));
        @(negedge clk);
        check("R7 one cycle", {31'd0, trap_req}, 32'd0);
        op(5'b00011);
        check("R7 disabled causes", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_ovf_quiet();
        cpu_write(word(2'b00, 5'h0, 5'b11011, 5'h0, 1'b0));
        op(5'b00100);
        check("R8 no trap", {31'd0, trap_req}, 32'd0);
        check("R8 recorded", cpu_rdata, word(2'b00, 5'b00100, 5'b11011, 5'b00100, 1'b0));
    endtask

    task automatic t_cpu_trap();
        cpu_write(word(2'b00, 5'h0, 5'b01000, 5'b01000, 1'b0));
        check("R9 write trap", {31'd0, trap_req}, 32'd1);
        @(negedge clk);
        check("R9 one cycle", {31'd0, trap_req}, 32'd0);
        cpu_write(word(2'b00, 5'h0, 5'b10000, 5'b01000, 1'b0));
        check("R9 no overlap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_collide();
        cpu_write(word(2'b00, 5'h0, 5'h1F, 5'h0, 1'b0));
        op_done = 1'b1; op_flags = 5'h1F; cmp_done = 1'b1; cmp_true = 1'b1;
        cpu_wr = 1'b1; cpu_wdata = word(2'b01, 5'h0, 5'h0, 5'h0, 1'b0);
        @(negedge clk);
        op_done = 1'b0; op_flags = '0; cmp_done = 1'b0; cmp_true = 1'b0;
        cpu_wr = 1'b0; cpu_wdata = '0;
        check("R10 write wins", cpu_rdata, word(2'b01, 5'h0, 5'h0, 5'h0, 1'b0));
        check("R10 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_rmode();
        t_cause_sticky();
        t_idle();
        t_cmp();
        t_trap();
        t_ovf_quiet();
        t_cpu_trap();
        t_collide();
        summary();
    end
endmodule